// File: doc/BRIEF.md
# Static Branch Direction Predictor

This block sits in the instruction fetch path and decides, for each decoded branch, whether fetch should carry on at the next sequential word or jump to the branch target. The decision uses fixed rules and keeps no history. An unconditional branch is always predicted taken. A conditional branch follows a compiler-supplied hint when one is present. Without a hint, a conditional branch is predicted taken when its target lies at or below its own address (a loop back-edge) and not taken when its target lies ahead.

The predicted direction and the resulting fetch address are registered and appear one clock after the branch strobe. When the branch later resolves, the actual outcome is presented on the resolve port. A saturating counter records how often that outcome disagreed with the registered prediction, which gives a simple measure of predictor quality.

Top module: `static_branch_predictor`

## Requirements
- R1: An unconditional branch (`br_uncond`=1) is predicted taken whatever its hint and whatever the relative position of its target.
- R2: A conditional branch with no hint (`br_hint`=2'b00) is predicted taken when `br_target` <= `br_pc` (unsigned compare); a target equal to the branch address counts as backward.
- R3: A conditional branch with no hint is predicted not taken when `br_target` > `br_pc`.
- R4: On a conditional branch, hint 2'b01 (likely taken) forces a taken prediction and hint 2'b10 (likely not taken) forces a not-taken prediction, whatever the target direction.
- R5: Hint 2'b11 is reserved and gives the same prediction as 2'b00.
- R6: One clock after `br_valid` is high, `pred_valid` is 1, `pred_taken` holds the decision, and `fetch_pc` is `br_target` if taken or `br_pc`+4 if not.
- R7: One clock after a cycle with `br_valid` low, `pred_valid` is 0 and `pred_taken` and `fetch_pc` keep their previous values.
- R8: On a clock with `res_valid` high, `miss_count` increases by one if `res_taken` differs from the current `pred_taken`, and stays unchanged otherwise; with `res_valid` low it stays unchanged.
- R9: `miss_count` saturates at its all-ones value (255 at the default width).
- R10: After synchronous active-low reset, `pred_valid`, `pred_taken`, `fetch_pc` and `miss_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| br_valid | input | 1 | A decoded branch is presented this cycle |
| br_uncond | input | 1 | 1 = unconditional branch, 0 = conditional |
| br_pc | input | ADDR_W | Address of the branch instruction |
| br_target | input | ADDR_W | Address the branch jumps to |
| br_hint | input | 2 | Compiler hint: 00 none, 01 likely taken, 10 likely not taken, 11 reserved |
| pred_valid | output | 1 | A prediction was made on the previous clock |
| pred_taken | output | 1 | Registered predicted direction |
| fetch_pc | output | ADDR_W | Registered next fetch address |
| res_valid | input | 1 | The actual outcome of the predicted branch is presented |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| miss_count | output | CNT_W | Saturating count of mispredictions |

## Verification
Directed branches are driven in each category: unconditional with conflicting hints, conditional backward, equal-address and forward targets without hint, and both hint values set against the direction the address rule would choose. The hint cases show whether the hint truly takes priority over the address comparison, and the equal-address case separates a <= compare from a < compare. Reserved-hint branches in both directions show whether 2'b11 falls back to the address rule instead of being read as one of the real hints. Resolve sequences with matching, mismatching and absent outcomes, followed by a long run of misses, separate correct counting from counting on every resolve and from wrap-around.

// File: rtl/sbp_pkg.sv
// Package: shared types for the static branch predictor.
// Assumes a 2-bit hint encoding supplied by the decoder.
package sbp_pkg;

    // Compiler hint field encoding.
    typedef enum logic [1:0] {
        HINT_NONE      = 2'b00,
        HINT_LIKELY    = 2'b01,
        HINT_UNLIKELY  = 2'b10,
        HINT_RESERVED  = 2'b11
    } hint_e;

endpackage

// File: rtl/sbp_dir_decide.sv
// Module: sbp_dir_decide
// Combinational direction rule. Unconditional branches are taken; a hint
// overrides the address rule for conditional branches; otherwise a target
// at or below the branch address is taken. Assumes unsigned addresses.
module sbp_dir_decide
    import sbp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              uncond,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] target,
    input  logic [1:0]        hint,
    output logic              taken
);

    logic backward;

    // Backward when target does not lie beyond the branch itself.
    always_comb backward = (target <= pc);

    // Priority: unconditional, then hint, then address direction.
    always_comb begin
        if (uncond) begin
            taken = 1'b1;
        end else begin
            case (hint_e'(hint))
                HINT_LIKELY:   taken = 1'b1;
                HINT_UNLIKELY: taken = 1'b0;
                default:       taken = backward;
            endcase
        end
    end

endmodule

// File: rtl/sbp_next_addr.sv
// Module: sbp_next_addr
// Chooses the next fetch address: branch target when predicted taken,
// otherwise the sequential word after the branch. Assumes fixed-size
// instructions of INSN_BYTES bytes.
module sbp_next_addr #(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] target,
    input  logic              taken,
    output logic [ADDR_W-1:0] next_pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    // Select redirect or fall-through address.
    always_comb next_pc = taken ? target : (pc + STEP);

endmodule

// File: rtl/sbp_miss_counter.sv
// Module: sbp_miss_counter
// Counts resolved branches whose actual direction differs from the
// registered prediction. Saturates at all ones. Assumes the resolve
// refers to the prediction currently held on pred_taken.
module sbp_miss_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic             res_taken,
    input  logic             pred_taken,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic miss;

    // A miss is a resolved outcome that disagrees with the prediction.
    always_comb miss = res_valid && (res_taken != pred_taken);

    // Saturating increment on each miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (miss && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

    assert_miss_increments_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_taken != pred_taken) && (count != CNT_MAX))
        |=> (count == $past(count) + 1'b1));

    assert_no_count_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid || (res_taken == pred_taken)) |=> $stable(count));

    assert_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX));

endmodule

// File: rtl/static_branch_predictor.sv
// Module: static_branch_predictor
// Top level. Registers the static direction decision and the next fetch
// address one clock after a branch strobe, and tracks mispredictions.
// Assumes the branch target is already computed by the decoder.
module static_branch_predictor #(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 4,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic              br_uncond,
    input  logic [ADDR_W-1:0] br_pc,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [1:0]        br_hint,
    output logic              pred_valid,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] fetch_pc,
    input  logic              res_valid,
    input  logic              res_taken,
    output logic [CNT_W-1:0]  miss_count
);

    logic              dec_taken;
    logic [ADDR_W-1:0] dec_next;

    sbp_dir_decide #(.ADDR_W(ADDR_W)) u_dir (
        .uncond (br_uncond),
        .pc     (br_pc),
        .target (br_target),
        .hint   (br_hint),
        .taken  (dec_taken)
    );

    sbp_next_addr #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_addr (
        .pc      (br_pc),
        .target  (br_target),
        .taken   (dec_taken),
        .next_pc (dec_next)
    );

    // Capture the prediction when a branch is presented; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid <= 1'b0;
            pred_taken <= 1'b0;
            fetch_pc   <= '0;
        end else begin
            pred_valid <= br_valid;
            if (br_valid) begin
                pred_taken <= dec_taken;
                fetch_pc   <= dec_next;
            end
        end
    end

    sbp_miss_counter #(.CNT_W(CNT_W)) u_miss (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid  (res_valid),
        .res_taken  (res_taken),
        .pred_taken (pred_taken),
        .count      (miss_count)
    );

    assert_uncond_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_uncond) |=> pred_taken);

    assert_hint_likely_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !br_uncond && (br_hint == 2'b01)) |=> pred_taken);

    assert_hint_unlikely_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !br_uncond && (br_hint == 2'b10)) |=> !pred_taken);

    assert_fetch_address_R6: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (pred_valid &&
            (fetch_pc == (pred_taken ? $past(br_target)
                                     : $past(br_pc) + ADDR_W'(INSN_BYTES)))));

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> (!pred_valid && $stable(pred_taken) && $stable(fetch_pc)));

endmodule

// File: tb/test_static_branch_predictor.sv
// Directed bench for static_branch_predictor: one task per scenario.
module test_static_branch_predictor;

    localparam int AW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          br_valid, br_uncond;
    logic [AW-1:0] br_pc, br_target;
    logic [1:0]    br_hint;
    logic          pred_valid, pred_taken;
    logic [AW-1:0] fetch_pc;
    logic          res_valid, res_taken;
    logic [CW-1:0] miss_count;

    int checks = 0;
    int failures = 0;
    int model_count = 0;
    bit done = 0;

    always #2 clk = ~clk;

    static_branch_predictor #(.ADDR_W(AW), .INSN_BYTES(4), .CNT_W(CW)) i_static_branch_predictor (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_uncond(br_uncond), .br_pc(br_pc),
        .br_target(br_target), .br_hint(br_hint),
        .pred_valid(pred_valid), .pred_taken(pred_taken), .fetch_pc(fetch_pc),
        .res_valid(res_valid), .res_taken(res_taken), .miss_count(miss_count)
    );

    // Record one check; print a FAIL line on mismatch.
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Present one branch and check the registered prediction one clock later.
    task automatic do_branch(input bit unc, input logic [31:0] pc, input logic [31:0] tgt,
                             input logic [1:0] hint, input bit exp_taken, input string req);
        logic [31:0] exp_pc;
        @(negedge clk);
        br_valid = 1'b1; br_uncond = unc; br_pc = pc; br_target = tgt; br_hint = hint;
        @(negedge clk);
        br_valid = 1'b0;
        exp_pc = exp_taken ? tgt : pc + 32'd4;
        check(pred_valid == 1'b1, {req, " pred_valid"}, {31'd0, pred_valid}, 32'd1);
        check(pred_taken == exp_taken, {req, " pred_taken"}, {31'd0, pred_taken}, {31'd0, exp_taken});
        check(fetch_pc == exp_pc, {req, " R6 fetch_pc"}, fetch_pc, exp_pc);
    endtask

    // Present one resolve and check the miss count one clock later.
    task automatic do_resolve(input bit vld, input bit act, input bit cur_pred, input bit chk);
        @(negedge clk);
        res_valid = vld; res_taken = act;
        if (vld && (act != cur_pred) && model_count < 255) model_count++;
        @(negedge clk);
        res_valid = 1'b0;
        if (chk)
            check(miss_count == CW'(model_count), "R8 miss_count",
                  {24'd0, miss_count}, model_count);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; br_valid = 1'b0; br_uncond = 1'b0; br_pc = '0; br_target = '0;
        br_hint = 2'b00; res_valid = 1'b0; res_taken = 1'b0;
        repeat (3) @(negedge clk);
        check(pred_valid == 1'b0, "R10 pred_valid", {31'd0, pred_valid}, 0);
        check(pred_taken == 1'b0, "R10 pred_taken", {31'd0, pred_taken}, 0);
        check(fetch_pc == '0, "R10 fetch_pc", fetch_pc, 0);
        check(miss_count == '0, "R10 miss_count", {24'd0, miss_count}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_uncond();
        do_branch(1'b1, 32'h1000, 32'h2000, 2'b10, 1'b1, "R1 fwd+unlikely");
        do_branch(1'b1, 32'h3000, 32'h0400, 2'b00, 1'b1, "R1 backward");
    endtask

    task automatic t_no_hint();
        do_branch(1'b0, 32'h4000, 32'h3ff0, 2'b00, 1'b1, "R2 backward");
        do_branch(1'b0, 32'h5000, 32'h5000, 2'b00, 1'b1, "R2 equal");
        do_branch(1'b0, 32'h5000, 32'h5004, 2'b00, 1'b0, "R3 forward");
        do_branch(1'b0, 32'h0, 32'hffff_fff0, 2'b00, 1'b0, "R3 forward far");
    endtask

    task automatic t_hints();
        do_branch(1'b0, 32'h6000, 32'h7000, 2'b01, 1'b1, "R4 likely fwd");
        do_branch(1'b0, 32'h6000, 32'h1000, 2'b10, 1'b0, "R4 unlikely back");
    endtask

    task automatic t_reserved();
        do_branch(1'b0, 32'h8000, 32'h7000, 2'b11, 1'b1, "R5 rsvd back");
        do_branch(1'b0, 32'h8000, 32'h9000, 2'b11, 1'b0, "R5 rsvd fwd");
    endtask

    task automatic t_idle_hold();
        do_branch(1'b0, 32'hA000, 32'h9000, 2'b00, 1'b1, "R7 setup");
        @(negedge clk);
        check(pred_valid == 1'b0, "R7 pred_valid", {31'd0, pred_valid}, 0);
        check(pred_taken == 1'b1, "R7 pred_taken", {31'd0, pred_taken}, 1);
        check(fetch_pc == 32'h9000, "R7 fetch_pc", fetch_pc, 32'h9000);
    endtask

    task automatic t_mispredict();
        do_branch(1'b1, 32'hB000, 32'hC000, 2'b00, 1'b1, "R8 setup");
        do_resolve(1'b1, 1'b0, 1'b1, 1'b1);
        do_resolve(1'b1, 1'b1, 1'b1, 1'b1);
        do_resolve(1'b0, 1'b0, 1'b1, 1'b1);
        do_resolve(1'b1, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_saturate();
        do_branch(1'b0, 32'hD000, 32'hE000, 2'b00, 1'b0, "R9 setup");
        for (int i = 0; i < 300; i++) do_resolve(1'b1, 1'b1, 1'b0, 1'b0);
        check(miss_count == 8'hFF, "R9 saturated", {24'd0, miss_count}, 32'hFF);
        do_resolve(1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_uncond();
        t_no_hint();
        t_hints();
        t_reserved();
        t_idle_hold();
        t_mispredict();
        t_saturate();
        report();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

endmodule